// File: doc/BRIEF.md
# Cold/Warm Reset Qualifier and Access Gate

This block supervises reset for a memory-and-logic subsystem. It watches a digital power-good flag, a digital supply-above-lockout flag and an active-low reset pin. It decides whether each reset is cold or warm. A cold reset is the first one after power becomes good. Every later one is warm. Each kind must meet its own minimum low time, measured in clock cycles. The cycle counts come from nanosecond limits divided by the clock period, with any fraction rounded up.

After a qualified release, memory access stays blocked for a fixed recovery window, and then access-ready goes high. While reset is pending or the window is running, the write-strobe and chip-select pass-throughs are held inactive, and flash write starts are refused. Write starts are also refused whenever the supply is below lockout. Logic-output validity follows the loading of configuration after power-up, so it stays high through warm resets. The flash mode output requests read-array mode until the first cold reset has completed.

Top module: `rst_qualify_gate`

## Requirements
- R1: After power-good rises, the first qualified release is a cold reset. It needs the synchronized pin low for at least COLD_C = ceil(COLD_MIN_NS / CLK_PERIOD_NS) consecutive cycles, counted only while power-good is high. It also needs configuration loading to be finished. A release with COLD_C-1 low cycles does not qualify.
- R2: Once a cold reset has completed, a release qualifies as warm after at least WARM_C = ceil(WARM_MIN_NS / CLK_PERIOD_NS) low cycles. WARM_C-1 low cycles do not qualify.
- R3: A release that falls short of its minimum sets pw_err_o. After a short cold pulse, the block stays held in reset with access_ready_o low. After a short warm pulse, it returns to operation without a recovery window.
- R4: The reset pin passes through two synchronizer flops. Take the first clock edge that samples the released pin as edge 1. After a qualified release, access_ready_o is first high after edge REC_C+3, where REC_C = ceil(RECOVERY_NS / CLK_PERIOD_NS).
- R5: pw_err_o is sticky and is cleared by the next qualified release. reset_kind_o gives the kind of the last qualified release: 0 for cold, 1 for warm.
- R6: logic_valid_o rises CFG_C = ceil(CFG_LOAD_NS / CLK_PERIOD_NS) edges after the first edge at which power-good is seen high. It stays high through warm resets and falls within two edges of power-good dropping.
- R7: flash_rd_array_o is 1 while power is down and until a cold reset has qualified. It is 0 afterwards.
- R8: flash_wr_start_o equals flash_wr_req_i only while access_ready_o and vcc_ok_i are both 1. Otherwise it is 0.
- R9: wr_strobe_n_o and chip_sel_n_o copy their inputs only while access is ready and the synchronized pin is high. Otherwise both are driven to 1.
- R10: A drop of power-good returns the block to power-down on the next edge, with access_ready_o at 0. The next reset is then judged as cold, so a pulse long enough for warm but shorter than COLD_C sets pw_err_o and keeps access blocked.
- R11: While rst is high, the outputs are: access_ready_o 0, pw_err_o 0, reset_kind_o 0, logic_valid_o 0, flash_rd_array_o 1, strobes 1 and flash_wr_start_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply steady flag |
| vcc_ok_i | input | 1 | Supply above write-lockout level |
| rst_pin_n_i | input | 1 | Asynchronous active-low reset pin |
| wr_strobe_n_i | input | 1 | Write strobe from host, active low |
| chip_sel_n_i | input | 1 | Memory chip select from decoder, active low |
| flash_wr_req_i | input | 1 | Request to start a flash write cycle |
| wr_strobe_n_o | output | 1 | Gated write strobe, active low |
| chip_sel_n_o | output | 1 | Gated chip select, active low |
| flash_wr_start_o | output | 1 | Permitted flash write start |
| flash_rd_array_o | output | 1 | Forces flash into read-array mode |
| logic_valid_o | output | 1 | Configuration loaded; logic outputs valid |
| access_ready_o | output | 1 | Memory access allowed |
| reset_kind_o | output | 1 | Kind of last qualified reset, 1 = warm |
| pw_err_o | output | 1 | Sticky pulse-width error |

## Verification
The bench builds the block with a 20 ns period and the cold limit shortened to 400 ns, which gives COLD_C = 20. The warm limit stays at 150 ns, so WARM_C = 8 and the rounding-up is exercised. Recovery is 120 ns (REC_C = 6) and configuration loading is 200 ns (CFG_C = 10). These values bring the one-cycle boundaries of both pulse kinds, the exact recovery and configuration edges, and a power loss followed by a second cold sequence within a few hundred cycles.

// File: rtl/rqg_pkg.sv
package rqg_pkg;

    typedef enum logic [2:0] {
        RQ_OFF       = 3'd0,
        RQ_COLD_HOLD = 3'd1,
        RQ_RECOVER   = 3'd2,
        RQ_RUN       = 3'd3,
        RQ_WARM_LOW  = 3'd4
    } rq_state_e;

    typedef struct packed {
        logic kind_warm;
        logic pw_err;
    } rq_flags_t;

    typedef struct packed {
        logic level;
        logic rise;
    } rq_pin_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rqg_pin_sync.sv
module rqg_pin_sync
    import rqg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pin_n_i,
    output rq_pin_t pin_o
);
    logic s1, s2, s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s1     <= pin_n_i;
            s2     <= s1;
            s_prev <= s2;
        end
    end

    always_comb begin
        pin_o.level = s2;
        pin_o.rise  = s2 & ~s_prev;
    end
endmodule

// File: rtl/rqg_pulse_meter.sv
module rqg_pulse_meter #(
    parameter int unsigned MAX_COUNT = 8,
    parameter int unsigned W         = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         pin_level,
    output logic [W-1:0] low_cnt
);
    localparam logic [W-1:0] CAP = W'(MAX_COUNT);

    always_ff @(posedge clk) begin
        if (rst || !enable || pin_level) begin
            low_cnt <= '0;
        end else if (low_cnt != CAP) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r1_count_capped: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= CAP);
endmodule

// File: rtl/rqg_interval_timer.sv
module rqg_interval_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LAST);

    a_r4_timer_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/rst_qualify_gate.sv
module rst_qualify_gate
    import rqg_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned COLD_MIN_NS   = 1_000_000,
    parameter int unsigned WARM_MIN_NS   = 150,
    parameter int unsigned RECOVERY_NS   = 120,
    parameter int unsigned CFG_LOAD_NS   = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    input  logic vcc_ok_i,
    input  logic rst_pin_n_i,
    input  logic wr_strobe_n_i,
    input  logic chip_sel_n_i,
    input  logic flash_wr_req_i,
    output logic wr_strobe_n_o,
    output logic chip_sel_n_o,
    output logic flash_wr_start_o,
    output logic flash_rd_array_o,
    output logic logic_valid_o,
    output logic access_ready_o,
    output logic reset_kind_o,
    output logic pw_err_o
);
    localparam int unsigned COLD_C = ns_to_cyc(COLD_MIN_NS, CLK_PERIOD_NS);
    localparam int unsigned WARM_C = ns_to_cyc(WARM_MIN_NS, CLK_PERIOD_NS);
    localparam int unsigned REC_C  = ns_to_cyc(RECOVERY_NS, CLK_PERIOD_NS);
    localparam int unsigned CFG_C  = ns_to_cyc(CFG_LOAD_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_C  = umax(COLD_C, WARM_C);
    localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] COLD_L = CNT_W'(COLD_C);
    localparam logic [CNT_W-1:0] WARM_L = CNT_W'(WARM_C);

    rq_state_e        state, nxt;
    rq_flags_t        flags;
    rq_pin_t          pin;
    logic [CNT_W-1:0] low_cnt;
    logic             rec_expired, cfg_expired, cfg_loaded;
    logic             cold_ok, warm_ok, valid_evt, short_evt, gate_open;

    rqg_pin_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (rst_pin_n_i),
        .pin_o   (pin)
    );

    rqg_pulse_meter #(.MAX_COUNT(MAX_C), .W(CNT_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .enable    (state != RQ_OFF),
        .pin_level (pin.level),
        .low_cnt   (low_cnt)
    );

    rqg_interval_timer #(.CYCLES(REC_C)) u_recover (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != RQ_RECOVER),
        .run     (state == RQ_RECOVER),
        .expired (rec_expired)
    );

    rqg_interval_timer #(.CYCLES(CFG_C)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == RQ_OFF),
        .run     (1'b1),
        .expired (cfg_expired)
    );

    always_comb begin
        cold_ok   = (low_cnt >= COLD_L) && cfg_loaded;
        warm_ok   = (low_cnt >= WARM_L);
        valid_evt = pwr_good_i && pin.rise &&
                    (((state == RQ_COLD_HOLD) && cold_ok) ||
                     ((state == RQ_WARM_LOW) && warm_ok));
        short_evt = pwr_good_i && pin.rise &&
                    (((state == RQ_COLD_HOLD) && !cold_ok) ||
                     ((state == RQ_WARM_LOW) && !warm_ok));
    end

    always_comb begin
        nxt = state;
        if (!pwr_good_i) begin
            nxt = RQ_OFF;
        end else begin
            unique case (state)
                RQ_OFF:       nxt = RQ_COLD_HOLD;
                RQ_COLD_HOLD: if (valid_evt) nxt = RQ_RECOVER;
                RQ_RECOVER: begin
                    if (!pin.level)       nxt = RQ_WARM_LOW;
                    else if (rec_expired) nxt = RQ_RUN;
                end
                RQ_RUN:       if (!pin.level) nxt = RQ_WARM_LOW;
                RQ_WARM_LOW: begin
                    if (valid_evt)      nxt = RQ_RECOVER;
                    else if (short_evt) nxt = RQ_RUN;
                end
                default:      nxt = RQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RQ_OFF;
            flags      <= '0;
            cfg_loaded <= 1'b0;
        end else begin
            state <= nxt;
            if (valid_evt) begin
                flags.kind_warm <= (state == RQ_WARM_LOW);
                flags.pw_err    <= 1'b0;
            end else if (short_evt) begin
                flags.pw_err    <= 1'b1;
            end
            if (state == RQ_OFF)  cfg_loaded <= 1'b0;
            else if (cfg_expired) cfg_loaded <= 1'b1;
        end
    end

    always_comb begin
        gate_open        = (state == RQ_RUN) && pin.level;
        wr_strobe_n_o    = gate_open ? wr_strobe_n_i : 1'b1;
        chip_sel_n_o     = gate_open ? chip_sel_n_i  : 1'b1;
        access_ready_o   = (state == RQ_RUN);
        flash_wr_start_o = flash_wr_req_i && vcc_ok_i && access_ready_o;
        flash_rd_array_o = (state == RQ_OFF) || (state == RQ_COLD_HOLD);
        logic_valid_o    = cfg_loaded;
        reset_kind_o     = flags.kind_warm;
        pw_err_o         = flags.pw_err;
    end

    a_r10_off_after_power_loss: assert property (@(posedge clk) disable iff (rst)
        !$past(pwr_good_i) |-> (state == RQ_OFF));

    a_r4_ready_after_window: assert property (@(posedge clk) disable iff (rst)
        ($rose(access_ready_o) && ($past(state) == RQ_RECOVER)) |-> $past(rec_expired));

    a_r5_err_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
        ((state == RQ_RECOVER) && ($past(state) != RQ_RECOVER)) |-> !pw_err_o);

    a_r6_valid_in_warm: assert property (@(posedge clk) disable iff (rst)
        (state == RQ_WARM_LOW) |-> logic_valid_o);

    a_r8_write_needs_ready: assert property (@(posedge clk) disable iff (rst)
        flash_wr_start_o |-> (access_ready_o && vcc_ok_i));

    a_r9_strobes_idle_in_reset: assert property (@(posedge clk) disable iff (rst)
        !pin.level |-> (wr_strobe_n_o && chip_sel_n_o));
endmodule

// File: tb/tb_rst_qualify_gate.sv
module tb_rst_qualify_gate;
    localparam int PERIOD = 20;
    localparam int COLD_C = (400 + PERIOD - 1) / PERIOD;
    localparam int WARM_C = (150 + PERIOD - 1) / PERIOD;
    localparam int REC_C  = (120 + PERIOD - 1) / PERIOD;
    localparam int CFG_C  = (200 + PERIOD - 1) / PERIOD;

    typedef struct packed {
        int   len;
        logic exp_err;
        logic exp_kind;
    } warm_vec_t;

    localparam warm_vec_t WARM_TAB [4] = '{
        '{len: WARM_C - 1, exp_err: 1'b1, exp_kind: 1'b0},
        '{len: WARM_C,     exp_err: 1'b0, exp_kind: 1'b1},
        '{len: 3,          exp_err: 1'b1, exp_kind: 1'b1},
        '{len: 30,         exp_err: 1'b0, exp_kind: 1'b1}
    };

    logic clk = 1'b0;
    logic rst, pwr_good, vcc_ok, pin_n, wr_n, cs_n, wr_req;
    logic wr_n_o, cs_n_o, wr_start, rd_array, lvalid, ready, kind, perr;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    rst_qualify_gate #(
        .CLK_PERIOD_NS(PERIOD), .COLD_MIN_NS(400), .WARM_MIN_NS(150),
        .RECOVERY_NS(120), .CFG_LOAD_NS(200)
    ) dut (
        .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .vcc_ok_i(vcc_ok),
        .rst_pin_n_i(pin_n), .wr_strobe_n_i(wr_n), .chip_sel_n_i(cs_n),
        .flash_wr_req_i(wr_req), .wr_strobe_n_o(wr_n_o), .chip_sel_n_o(cs_n_o),
        .flash_wr_start_o(wr_start), .flash_rd_array_o(rd_array),
        .logic_valid_o(lvalid), .access_ready_o(ready), .reset_kind_o(kind),
        .pw_err_o(perr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_low(input int len);
        @(negedge clk) pin_n = 1'b0;
        repeat (len) @(negedge clk);
        pin_n = 1'b1;
    endtask

    task automatic wait_ready(output int edges);
        edges = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (ready) begin
                edges = i;
                break;
            end
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int lat;
        rst = 1'b1; pwr_good = 1'b0; vcc_ok = 1'b1; pin_n = 1'b0;
        wr_n = 1'b0; cs_n = 1'b0; wr_req = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", ready, 0);
        chk("R11 err", perr, 0);
        chk("R11 kind", kind, 0);
        chk("R11 valid", lvalid, 0);
        chk("R11 rd_array", rd_array, 1);
        chk("R11 strobe", wr_n_o, 1);
        chk("R11 cs", cs_n_o, 1);
        chk("R11 wr_start", wr_start, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R6 configuration load timing, counted from power-good
        pwr_good = 1'b1;
        for (int i = 1; i <= CFG_C + 1; i++) begin
            @(negedge clk);
            if (i == CFG_C)     chk("R6 valid before load", lvalid, 0);
            if (i == CFG_C + 1) chk("R6 valid after load", lvalid, 1);
        end
        // R1/R3 short cold release keeps reset held
        pin_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R3 cold short err", perr, 1);
        chk("R3 cold short held", ready, 0);
        chk("R7 rd_array held", rd_array, 1);
        pulse_low(COLD_C - 1);
        repeat (12) @(negedge clk);
        chk("R1 cold one short", ready, 0);
        chk("R1 cold one short err", perr, 1);
        // R1 exact cold minimum, R4 recovery latency
        pulse_low(COLD_C);
        wait_ready(lat);
        chk("R4 cold latency", lat, REC_C + 3);
        chk("R5 err cleared", perr, 0);
        chk("R5 kind cold", kind, 0);
        chk("R7 rd_array released", rd_array, 0);
        // R9 and R8 in operation
        @(negedge clk);
        chk("R9 strobe pass", wr_n_o, 0);
        chk("R9 cs pass", cs_n_o, 0);
        chk("R8 write start", wr_start, 1);
        vcc_ok = 1'b0;
        @(negedge clk);
        chk("R8 lockout", wr_start, 0);
        vcc_ok = 1'b1;
        // R2/R3/R5 warm pulse table
        foreach (WARM_TAB[v]) begin
            @(negedge clk) pin_n = 1'b0;
            for (int i = 0; i < WARM_TAB[v].len; i++) begin
                @(negedge clk);
                if (i == 2) begin
                    chk("R9 strobe forced", wr_n_o, 1);
                    chk("R6 valid in warm", lvalid, 1);
                    chk("R8 no start in reset", wr_start, 0);
                end
            end
            pin_n = 1'b1;
            if (!WARM_TAB[v].exp_err) begin
                wait_ready(lat);
                chk("R4 warm latency", lat, REC_C + 3);
            end else begin
                repeat (12) @(negedge clk);
                chk("R3 warm short resumes", ready, 1);
            end
            chk("R2 warm err", perr, WARM_TAB[v].exp_err);
            chk("R5 warm kind", kind, WARM_TAB[v].exp_kind);
        end
        // R10 power loss then cold judgement
        @(negedge clk) pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 ready dropped", ready, 0);
        chk("R7 rd_array on loss", rd_array, 1);
        chk("R6 valid dropped", lvalid, 0);
        chk("R8 start on loss", wr_start, 0);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        pulse_low(WARM_C);
        repeat (12) @(negedge clk);
        chk("R10 warm length rejected", perr, 1);
        chk("R10 still held", ready, 0);
        pulse_low(COLD_C);
        wait_ready(lat);
        chk("R10 cold latency", lat, REC_C + 3);
        chk("R10 kind cold", kind, 0);
        chk("R10 err cleared", perr, 0);
        summary();
    end
endmodule